// File: doc/BRIEF.md
# Split-Endian Access Byte-Lane Swapper

This block sits between a big-endian core datapath and the memory side of that core. It holds two mode bits of the machine-state word: a little-endian bit and a split-endian bit. From these it picks the byte order of instruction fetches and, separately, the byte order of data accesses. It then reverses the byte lanes of fetched instruction words and of load and store data whenever the chosen order is little-endian. The core itself is always taken to be big-endian.

Instruction order follows the little-endian bit alone. Data order follows the exclusive-OR of the two bits. A user-level command writes only the split-endian bit, so software can flip data order for a short sequence of code without a privileged write and without touching instruction order. Data accesses are 1, 2, 4 or 8 bytes wide and right-justified in the data bus. Only the lanes that the access covers are reordered.

Top module: `endian_lane_swapper`

## Requirements
- R1: After reset, both mode bits read as clear. Instruction words, load data and store data then pass through unchanged.
- R2: The instruction word comes out byte-reversed when the little-endian bit is 1. It comes out unchanged when that bit is 0, whatever the split-endian bit holds.
- R3: Data is byte-reversed exactly when little-endian XOR split-endian is 1. The four combinations of (split, little) give: (0,0) big data and big instructions, (0,1) little and little, (1,0) little data and big instructions, (1,1) big data and little instructions.
- R4: The size code on `ld_size` and `st_size` is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A swap reverses only the low 2^code byte lanes, and higher lanes pass through unchanged.
- R5: A 1-byte access (size code 0) is never altered in any mode.
- R6: Store data uses the same swap decision and the same lane rule as load data.
- R7: A mode change takes effect for accesses presented in the cycle after the write. An access presented in the same cycle as the write sees the old mode.
- R8: The split-endian set command (`sle_cmd_en`, value `sle_cmd_val`) changes only the split-endian bit and leaves the little-endian bit as it was.
- R9: If a full mode-word write and the split-endian command happen in the same cycle, the command's value wins for the split-endian bit. The write still sets the little-endian bit.
- R10: In the 64-bit mode word written on `msr_wdata`, the little-endian bit is LSB-0 bit 0 and the split-endian bit is LSB-0 bit 58 (bit 5 counting from the MSB as 0). No other bit has any effect.
- R11: With the split-endian bit clear, data order always equals instruction order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_we | input | 1 | Write strobe for the mode word |
| msr_wdata | input | MSR_W | Mode word; only the little and split bits are kept |
| sle_cmd_en | input | 1 | User-level split-endian set command |
| sle_cmd_val | input | 1 | New split-endian bit value |
| if_raw | input | INSN_W | Instruction word as fetched from memory |
| if_word | output | INSN_W | Instruction word in core order |
| ld_size | input | SZ_W | Load size code |
| ld_raw | input | DATA_W | Load data as read from memory, right-justified |
| ld_data | output | DATA_W | Load data in core order |
| st_size | input | SZ_W | Store size code |
| st_din | input | DATA_W | Store data from the core, right-justified |
| st_dout | output | DATA_W | Store data in memory order |

## Verification
The assertions assume the size codes never exceed the widest access the data bus carries. The bench only drives codes 0 to 3 on the 64-bit default bus. The checks on lanes above a 2-byte access assume that the data bus is wider than 16 bits. Mode writes and commands are driven away from the clock edge. The bench holds each access stable through the edge that follows, so the same-cycle rule is seen on a stable input.

// File: rtl/els_pkg.sv
package els_pkg;
   // default mode-word geometry (LSB-0 positions)
   localparam int MODE_W_DEF   = 64;
   localparam int LE_POS_DEF   = 0;
   localparam int SLE_POS_DEF  = MODE_W_DEF - 1 - 5;

   // number of byte lanes covered by a size code
   function automatic int lanes_of(input int size_code);
      return 1 << size_code;
   endfunction
endpackage

// File: rtl/els_mode_reg.sv
module els_mode_reg #(
   parameter int MSR_W   = els_pkg::MODE_W_DEF,
   parameter int LE_POS  = els_pkg::LE_POS_DEF,
   parameter int SLE_POS = els_pkg::SLE_POS_DEF,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msr_we,
   input  logic [MSR_W-1:0] msr_wdata,
   input  logic             sle_cmd_en,
   input  logic             sle_cmd_val,
   output logic             mode_le,
   output logic             mode_sle
);
   if (LE_POS < 0 || LE_POS >= MSR_W) begin : g_bad_le
      $error("els_mode_reg: LE_POS outside mode word");
   end
   if (SLE_POS < 0 || SLE_POS >= MSR_W || SLE_POS == LE_POS) begin : g_bad_sle
      $error("els_mode_reg: SLE_POS invalid");
   end

   logic le_q;
   logic le_d;

   // only the two meaningful bits are stored
   always_comb begin
      le_d = le_q;
      if (msr_we) le_d = msr_wdata[LE_POS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) le_q <= 1'b0;
      else        le_q <= le_d;
   end
   assign mode_le = le_q;

   if (SPLIT_EN) begin : g_split
      logic sle_q;
      logic sle_d;
      always_comb begin
         sle_d = sle_q;
         if (msr_we)     sle_d = msr_wdata[SLE_POS];
         if (sle_cmd_en) sle_d = sle_cmd_val;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) sle_q <= 1'b0;
         else        sle_q <= sle_d;
      end
      assign mode_sle = sle_q;
      logic split_unused;
      assign split_unused = 1'b0;
   end else begin : g_nosplit
      assign mode_sle = 1'b0;
      logic split_unused;
      assign split_unused = sle_cmd_en ^ sle_cmd_val ^ msr_wdata[SLE_POS];
   end

   logic wdata_unused;
   assign wdata_unused = ^msr_wdata;
endmodule

// File: rtl/els_lane_rev.sv
module els_lane_rev #(
   parameter int LANES = 8,
   parameter int SZ_W  = 2
) (
   input  logic [LANES*8-1:0] din,
   input  logic [SZ_W-1:0]    size_code,
   input  logic               swap_en,
   output logic [LANES*8-1:0] dout
);
   localparam int LOG2_L = $clog2(LANES);
   localparam int W      = LANES * 8;

   if ((1 << LOG2_L) != LANES) begin : g_bad_lanes
      $error("els_lane_rev: LANES must be a power of two");
   end
   if ((1 << SZ_W) < LOG2_L + 1) begin : g_bad_szw
      $error("els_lane_rev: SZ_W too narrow for LANES");
   end

   wire logic [W-1:0] cand [LOG2_L+1];

   for (genvar k = 0; k <= LOG2_L; k++) begin : g_sz
      localparam int N = els_pkg::lanes_of(k);
      for (genvar b = 0; b < LANES; b++) begin : g_ln
         if (b < N) begin : g_rev
            assign cand[k][b*8 +: 8] = din[(N-1-b)*8 +: 8];
         end else begin : g_keep
            assign cand[k][b*8 +: 8] = din[b*8 +: 8];
         end
      end
   end

   always_comb begin
      dout = din;
      if (swap_en && int'(size_code) <= LOG2_L) dout = cand[size_code];
   end
endmodule

// File: rtl/endian_lane_swapper.sv
module endian_lane_swapper #(
   parameter int MSR_W    = els_pkg::MODE_W_DEF,
   parameter int LE_POS   = els_pkg::LE_POS_DEF,
   parameter int SLE_POS  = els_pkg::SLE_POS_DEF,
   parameter bit SPLIT_EN = 1'b1,
   parameter int INSN_W   = 32,
   parameter int DATA_W   = 64,
   localparam int DATA_LANES = DATA_W / 8,
   localparam int SZ_W       = $clog2($clog2(DATA_LANES) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msr_we,
   input  logic [MSR_W-1:0]  msr_wdata,
   input  logic              sle_cmd_en,
   input  logic              sle_cmd_val,
   input  logic [INSN_W-1:0] if_raw,
   output logic [INSN_W-1:0] if_word,
   input  logic [SZ_W-1:0]   ld_size,
   input  logic [DATA_W-1:0] ld_raw,
   output logic [DATA_W-1:0] ld_data,
   input  logic [SZ_W-1:0]   st_size,
   input  logic [DATA_W-1:0] st_din,
   output logic [DATA_W-1:0] st_dout
);
   localparam int INSN_LANES = INSN_W / 8;
   localparam int INSN_LOG2  = $clog2(INSN_LANES);
   localparam int INSN_SZ_W  = $clog2(INSN_LOG2 + 1);

   if (DATA_W % 8 != 0 || INSN_W % 8 != 0 || DATA_W < 8 || INSN_W < 8) begin : g_bad_w
      $error("endian_lane_swapper: widths must be whole bytes");
   end

   logic mode_le;
   logic mode_sle;
   logic insn_swap;
   logic data_swap;

   els_mode_reg #(
      .MSR_W(MSR_W), .LE_POS(LE_POS), .SLE_POS(SLE_POS), .SPLIT_EN(SPLIT_EN)
   ) u_mode (
      .clk(clk), .rst_n(rst_n),
      .msr_we(msr_we), .msr_wdata(msr_wdata),
      .sle_cmd_en(sle_cmd_en), .sle_cmd_val(sle_cmd_val),
      .mode_le(mode_le), .mode_sle(mode_sle)
   );

   // core is big-endian: swap exactly when chosen order is little
   assign insn_swap = mode_le;
   assign data_swap = mode_le ^ mode_sle;

   els_lane_rev #(.LANES(INSN_LANES), .SZ_W(INSN_SZ_W)) u_if_rev (
      .din(if_raw), .size_code(INSN_SZ_W'(INSN_LOG2)),
      .swap_en(insn_swap), .dout(if_word)
   );

   els_lane_rev #(.LANES(DATA_LANES), .SZ_W(SZ_W)) u_ld_rev (
      .din(ld_raw), .size_code(ld_size),
      .swap_en(data_swap), .dout(ld_data)
   );

   els_lane_rev #(.LANES(DATA_LANES), .SZ_W(SZ_W)) u_st_rev (
      .din(st_din), .size_code(st_size),
      .swap_en(data_swap), .dout(st_dout)
   );
endmodule

// File: rtl/els_checker.sv
module els_checker #(
   parameter int INSN_W = 32,
   parameter int DATA_W = 64,
   parameter int SZ_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msr_we,
   input logic              sle_cmd_en,
   input logic              sle_cmd_val,
   input logic [INSN_W-1:0] if_raw,
   input logic [INSN_W-1:0] if_word,
   input logic [SZ_W-1:0]   ld_size,
   input logic [DATA_W-1:0] ld_raw,
   input logic [DATA_W-1:0] ld_data,
   input logic [SZ_W-1:0]   st_size,
   input logic [DATA_W-1:0] st_din,
   input logic [DATA_W-1:0] st_dout,
   input logic              mode_le,
   input logic              mode_sle
);
   a_r2_insn_big: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_le |-> if_word == if_raw);

   a_r3_data_big: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_le == mode_sle) |-> ld_data == ld_raw);

   a_r5_byte_keep: assert property (@(posedge clk) disable iff (!rst_n)
      ld_size == '0 |-> ld_data == ld_raw);

   a_r6_store_same: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_size == st_size && ld_raw == st_din) |-> st_dout == ld_data);

   a_r7_cmd_next: assert property (@(posedge clk) disable iff (!rst_n)
      sle_cmd_en |=> mode_sle == $past(sle_cmd_val));

   a_r8_le_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (sle_cmd_en && !msr_we) |=> mode_le == $past(mode_le));

   if (DATA_W > 16) begin : g_upper
      a_r4_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
         ld_size == SZ_W'(1) |-> ld_data[DATA_W-1:16] == ld_raw[DATA_W-1:16]);
   end
endmodule

bind endian_lane_swapper els_checker #(
   .INSN_W(INSN_W), .DATA_W(DATA_W), .SZ_W(SZ_W)
) u_els_chk (
   .clk(clk), .rst_n(rst_n), .msr_we(msr_we),
   .sle_cmd_en(sle_cmd_en), .sle_cmd_val(sle_cmd_val),
   .if_raw(if_raw), .if_word(if_word),
   .ld_size(ld_size), .ld_raw(ld_raw), .ld_data(ld_data),
   .st_size(st_size), .st_din(st_din), .st_dout(st_dout),
   .mode_le(mode_le), .mode_sle(mode_sle)
);

// File: tb/endian_lane_swapper_tb_top.sv
module endian_lane_swapper_tb_top;
   localparam int CLK_P = 10;
   localparam int SLE_BIT = 58;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msr_we = 1'b0;
   logic [63:0] msr_wdata = '0;
   logic        sle_cmd_en = 1'b0;
   logic        sle_cmd_val = 1'b0;
   logic [31:0] if_raw = '0;
   logic [31:0] if_word;
   logic [1:0]  ld_size = '0;
   logic [63:0] ld_raw = '0;
   logic [63:0] ld_data;
   logic [1:0]  st_size = '0;
   logic [63:0] st_din = '0;
   logic [63:0] st_dout;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   endian_lane_swapper dut_i (
      .clk(clk), .rst_n(rst_n), .msr_we(msr_we), .msr_wdata(msr_wdata),
      .sle_cmd_en(sle_cmd_en), .sle_cmd_val(sle_cmd_val),
      .if_raw(if_raw), .if_word(if_word),
      .ld_size(ld_size), .ld_raw(ld_raw), .ld_data(ld_data),
      .st_size(st_size), .st_din(st_din), .st_dout(st_dout)
   );

   function automatic logic [63:0] ref_rev(input logic [63:0] d, input int sz, input bit en);
      logic [63:0] r;
      int n;
      r = d;
      n = 1 << sz;
      if (en) for (int b = 0; b < n; b++) r[b*8 +: 8] = d[(n-1-b)*8 +: 8];
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // full mode write; returns at the next negedge with mode applied
   task automatic set_mode(input bit le, input bit sle);
      msr_we = 1'b1;
      msr_wdata = '0;
      msr_wdata[0] = le;
      msr_wdata[SLE_BIT] = sle;
      @(posedge clk);
      @(negedge clk);
      msr_we = 1'b0;
   endtask

   // check instruction, load and store paths for the current mode
   task automatic sweep(input string req, input bit le, input bit sle, input logic [63:0] pat);
      for (int sz = 0; sz < 4; sz++) begin
         ld_size = 2'(sz);
         st_size = 2'(3 - sz);
         ld_raw = pat;
         st_din = ~pat;
         if_raw = pat[47:16];
         #1;
         chk(req, ld_data, ref_rev(pat, sz, le ^ sle));
         chk("R6", st_dout, ref_rev(~pat, 3 - sz, le ^ sle));
         chk("R2", {32'h0, if_word}, ref_rev({32'h0, pat[47:16]}, 2, le));
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog got=hung exp=done");
      finish_run();
   end

   initial begin
      logic [63:0] pat;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: after reset everything passes through
      ld_size = 2'd3; ld_raw = 64'h0102030405060708;
      st_size = 2'd3; st_din = 64'h1122334455667788;
      if_raw = 32'hA1B2C3D4;
      #1;
      chk("R1", ld_data, 64'h0102030405060708);
      chk("R1", st_dout, 64'h1122334455667788);
      chk("R1", {32'h0, if_word}, 64'hA1B2C3D4);

      // R3/R4/R5/R11 sweep over all mode combinations and sizes
      for (int m = 0; m < 4; m++) begin
         @(negedge clk);
         set_mode(m[0], m[1]);
         for (int p = 0; p < 3; p++) begin
            pat = 64'h0123456789ABCDEF ^ (64'(p) * 64'h1F2E3D4C5B6A7988);
            sweep(m[1] ? "R3" : "R11", m[0], m[1], pat);
         end
         // R5: byte access untouched
         ld_size = 2'd0; ld_raw = 64'hDEADBEEFCAFEF00D; #1;
         chk("R5", ld_data, 64'hDEADBEEFCAFEF00D);
         // R4: 2-byte swap leaves upper lanes
         ld_size = 2'd1; #1;
         chk("R4", ld_data, (m[0] ^ m[1]) ? 64'hDEADBEEFCAFE0DF0 : 64'hDEADBEEFCAFEF00D);
      end

      // R7: write seen next cycle, not same cycle
      set_mode(1'b0, 1'b0);
      if_raw = 32'h11223344; ld_size = 2'd2; ld_raw = 64'h0000000055667788;
      msr_we = 1'b1; msr_wdata = 64'h1;
      #1;
      chk("R7", {32'h0, if_word}, 64'h11223344);
      chk("R7", ld_data, 64'h0000000055667788);
      @(posedge clk); @(negedge clk); msr_we = 1'b0; #1;
      chk("R7", {32'h0, if_word}, 64'h44332211);
      chk("R7", ld_data, 64'h0000000088776655);

      // R8: command flips data only, instructions stay little
      sle_cmd_en = 1'b1; sle_cmd_val = 1'b1;
      #1;
      chk("R7", ld_data, 64'h0000000088776655);
      @(posedge clk); @(negedge clk); sle_cmd_en = 1'b0; #1;
      chk("R8", {32'h0, if_word}, 64'h44332211);
      chk("R8", ld_data, 64'h0000000055667788);
      sle_cmd_en = 1'b1; sle_cmd_val = 1'b0;
      @(posedge clk); @(negedge clk); sle_cmd_en = 1'b0; #1;
      chk("R8", ld_data, 64'h0000000088776655);

      // R9: command beats same-cycle write on the split bit
      msr_we = 1'b1; msr_wdata = 64'h0; msr_wdata[SLE_BIT] = 1'b1;
      sle_cmd_en = 1'b1; sle_cmd_val = 1'b0;
      @(posedge clk); @(negedge clk); msr_we = 1'b0; sle_cmd_en = 1'b0; #1;
      chk("R9", ld_data, 64'h0000000055667788);
      chk("R9", {32'h0, if_word}, 64'h11223344);

      // R10: bit positions; bit 5 LSB-0 has no effect, bit 58 is split
      msr_we = 1'b1; msr_wdata = 64'h20;
      @(posedge clk); @(negedge clk); msr_we = 1'b0; #1;
      chk("R10", ld_data, 64'h0000000055667788);
      chk("R10", {32'h0, if_word}, 64'h11223344);
      msr_we = 1'b1; msr_wdata = 64'h0400000000000000;
      @(posedge clk); @(negedge clk); msr_we = 1'b0; #1;
      chk("R10", ld_data, 64'h0000000088776655);
      chk("R10", {32'h0, if_word}, 64'h11223344);

      // R1: reset clears both bits again
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk); rst_n = 1'b1; #1;
      chk("R1", ld_data, 64'h0000000055667788);
      chk("R1", {32'h0, if_word}, 64'h11223344);

      finish_run();
   end
endmodule